// File: doc/BRIEF.md
# Serial One-Wire CRC-8 Engine

This block computes the eight-bit check code used on one-wire sensor buses, one data bit at a time. It can also take a whole byte and feed its bits in itself. A host clears the register and then shifts in the 56 bits of a device identity code, or the 64 bits of a memory image, least significant bit of the first byte first. The running code is then available on `crc`.

To verify received data, the host keeps shifting and feeds the received check byte after the data. If the data arrived intact, the register ends at all zeros, and the `zero` flag shows this directly.

Bits can be fed singly through the bit port. A byte can be handed over through the byte port, and the block then spends eight cycles shifting it out low bit first. While a byte is being shifted, all new input is ignored.

Top module: `owcrc_engine`

## Requirements
- R1: After reset, `crc` is 8'h00, `zero` is 1, `busy` is 0 and `byte_done` is 0.
- R2: A `clr` pulse makes `crc` 8'h00 and `busy` 0 in the next cycle. It aborts a byte in progress, so no `byte_done` follows, and it overrides every other input.
- R3: An accepted bit (`bit_vld` high while idle, with no `byte_vld` and no `clr`) updates `crc` one cycle later. The rule is the reflected form of x^8+x^5+x^4+1: fb = crc[0] XOR bit, the register shifts right by one, and fb is XORed into bits 7, 3 and 2 (mask 8'h8C).
- R4: In a cycle with no accepted bit, no byte being shifted and no `clr`, `crc` holds its value.
- R5: A byte on `byte_dat` with `byte_vld` high while idle is accepted. `busy` is then high for exactly 8 cycles, during which byte_dat[0] through byte_dat[7] are applied in turn as in R3. `byte_done` pulses for one cycle, in the cycle after the last bit, together with `busy` returning low and the final `crc`.
- R6: While `busy` is high, `bit_vld` and `byte_vld` are ignored, and the result equals that of the accepted byte alone.
- R7: If `bit_vld` and `byte_vld` are both high while idle, the byte is taken and the bit is dropped.
- R8: `zero` is 1 exactly when `crc` is 8'h00.
- R9: The bytes 02,1C,B8,01,00,00,00 give `crc` = 8'hA2. Any data followed by its own check byte leaves `crc` at 8'h00, and a check byte with one flipped bit leaves it non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the register and any byte in progress |
| bit_vld | input | 1 | Single data bit is offered |
| bit_dat | input | 1 | Single data bit value |
| byte_vld | input | 1 | Byte is offered |
| byte_dat | input | 8 | Byte value, shifted LSB first |
| crc | output | 8 | Running check register |
| zero | output | 1 | Register is all zeros |
| busy | output | 1 | A byte is being shifted |
| byte_done | output | 1 | One-cycle pulse when a byte has been shifted |

## Verification
The bench builds the block with its default eight-bit width, mask 8'h8C and eight-bit byte port. These are the values at which the published check vector and the zero-residue property can be observed directly. It feeds the same sequences both bit by bit and byte by byte, so the two paths must agree with a reference model that is written independently of the RTL. The default byte width also keeps the busy window at eight cycles, which makes the clear-during-byte, input-while-busy and simultaneous-request cases cheap to reach.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;
  localparam int unsigned CRC_W = 8;
  typedef logic [CRC_W-1:0] crc_t;

  // one reflected LFSR step: feedback from LSB, right shift, masked xor
  function automatic crc_t crc_step(input crc_t cur, input logic d, input crc_t mask);
    logic fb;
    fb = cur[0] ^ d;
    return (cur >> 1) ^ (fb ? mask : '0);
  endfunction
endpackage

// File: rtl/owcrc_bitcore.sv
module owcrc_bitcore
  import owcrc_pkg::*;
#(
  parameter crc_t POLY = 8'h8C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step_en,
  input  logic step_d,
  output crc_t crc_q
);
  logic fb;
  crc_t nxt;

  assign fb = crc_q[0] ^ step_d;

  genvar i;
  for (i = 0; i < CRC_W; i++) begin : g_tap
    if (i == CRC_W - 1) begin : g_top
      assign nxt[i] = fb & POLY[i];
    end else begin : g_mid
      assign nxt[i] = crc_q[i+1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (clr)     crc_q <= '0;
    else if (step_en) crc_q <= nxt;
  end
endmodule

// File: rtl/owcrc_byte_feeder.sv
module owcrc_byte_feeder #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_dat,
  output logic              feed_vld,
  output logic              feed_bit,
  output logic              done
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign feed_vld = (cnt_q != '0);
  assign feed_bit = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (feed_vld) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - CNT_ONE;
      done  <= (cnt_q == CNT_ONE);
    end else begin
      done <= 1'b0;
      if (load) begin
        sh_q  <= load_dat;
        cnt_q <= CNT_FULL;
      end
    end
  end
endmodule

// File: rtl/owcrc_engine.sv
module owcrc_engine
  import owcrc_pkg::*;
#(
  parameter crc_t        POLY   = 8'h8C,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_dat,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic [CRC_W-1:0]  crc,
  output logic              zero,
  output logic              busy,
  output logic              byte_done
);
  logic bit_acc;
  logic byte_acc;
  logic feed_vld;
  logic feed_bit;
  logic step_en;
  logic step_d;
  crc_t crc_q;

  assign busy     = feed_vld;
  assign byte_acc = byte_vld & ~busy & ~clr;
  assign bit_acc  = bit_vld & ~byte_vld & ~busy & ~clr;
  assign step_en  = bit_acc | feed_vld;
  assign step_d   = feed_vld ? feed_bit : bit_dat;

  owcrc_byte_feeder #(.BYTE_W(BYTE_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .load(byte_acc), .load_dat(byte_dat),
    .feed_vld(feed_vld), .feed_bit(feed_bit), .done(byte_done)
  );

  owcrc_bitcore #(.POLY(POLY)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .step_en(step_en), .step_d(step_d), .crc_q(crc_q)
  );

  assign crc  = crc_q;
  assign zero = (crc_q == '0);
endmodule

// File: rtl/owcrc_engine_chk.sv
module owcrc_engine_chk
  import owcrc_pkg::*;
#(
  parameter crc_t POLY = 8'h8C
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       bit_dat,
  input logic       byte_vld,
  input logic       bit_vld,
  input logic [7:0] crc,
  input logic       busy,
  input logic       byte_done,
  input logic       bit_acc,
  input logic       byte_acc,
  input logic       step_en
);
  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0) && !busy && !byte_done);

  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_acc |=> crc == crc_step($past(crc), $past(bit_dat), POLY));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step_en) |=> $stable(crc));

  // R5
  byte_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc |=> busy);

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !busy && $past(busy));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bit_acc && !byte_acc);

  // R7
  byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && bit_vld && !busy && !clr) |-> byte_acc && !bit_acc);
endmodule

bind owcrc_engine owcrc_engine_chk #(.POLY(POLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .bit_dat(bit_dat),
  .byte_vld(byte_vld), .bit_vld(bit_vld), .crc(crc), .busy(busy),
  .byte_done(byte_done), .bit_acc(bit_acc), .byte_acc(byte_acc),
  .step_en(step_en)
);

// File: tb/owcrc_engine_test.sv
`timescale 1ns/1ps
module owcrc_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_dat = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_dat = '0;
  logic [7:0] crc;
  logic       zero, busy, byte_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  owcrc_engine uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .crc(crc), .zero(zero),
    .busy(busy), .byte_done(byte_done)
  );

  // reference: polynomial x^8+x^5+x^4+1 reflected, written bit by bit
  function automatic logic [7:0] ref_bit(input logic [7:0] c, input logic d);
    logic f;
    logic [7:0] n;
    f = c[0] ^ d;
    n[7] = f;
    n[6] = c[7];
    n[5] = c[6];
    n[4] = c[5];
    n[3] = c[4] ^ f;
    n[2] = c[3] ^ f;
    n[1] = c[2];
    n[0] = c[1];
    return n;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = ref_bit(r, b[k]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_dat = d;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output int lat);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_dat = b;
    @(negedge clk);
    byte_vld = 1'b0;
    lat = 0;
    while (!byte_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  localparam int NV = 4;
  localparam logic [63:0] V_DATA [NV] = '{
    64'h0000_0000_01B8_1C02,
    64'h0000_0000_01B8_1C02,
    64'h5001_464B_100C_FF7F,
    64'h0000_0000_0000_00FF
  };
  localparam int V_LEN [NV] = '{7, 7, 8, 1};
  localparam bit V_BYTES [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lat;
    logic [7:0] exp;
    logic [7:0] b;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 crc", crc, 8'h00);
    check("R1 zero", zero, 1'b1);
    check("R1 busy", busy, 1'b0);
    check("R1 done", byte_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R9, R3, R5, R8
    for (int v = 0; v < NV; v++) begin
      do_clr();
      exp = 8'h00;
      for (int i = 0; i < V_LEN[v]; i++) begin
        b = V_DATA[v][i*8 +: 8];
        exp = ref_byte(exp, b);
        if (V_BYTES[v]) begin
          send_byte(b, lat);
          check("R5 latency", lat, 8);
          check("R5 busy low at done", busy, 1'b0);
        end else begin
          for (int k = 0; k < 8; k++) begin
            logic [7:0] e1;
            e1 = ref_bit(crc, b[k]);
            send_bit(b[k]);
            if (k == 0) check("R3 single step", crc, e1);
          end
        end
      end
      check("R9 crc", crc, exp);
      if (v < 2) check("R9 known vector A2", crc, 8'hA2);
      check("R8 zero low", zero, (exp == 8'h00));
      send_byte(exp, lat);
      check("R9 residue", crc, 8'h00);
      check("R8 zero high", zero, 1'b1);
    end

    // R9 corrupted check byte
    do_clr();
    send_byte(8'h02, lat);
    send_byte(8'h1C, lat);
    exp = ref_byte(ref_byte(8'h00, 8'h02), 8'h1C);
    send_byte(exp ^ 8'h10, lat);
    check("R9 bad residue nonzero", (crc != 8'h00), 1'b1);

    // R4 idle hold
    exp = crc;
    repeat (5) @(negedge clk);
    check("R4 hold", crc, exp);

    // R5 done is one cycle
    send_byte(8'h3A, lat);
    @(negedge clk);
    check("R5 done pulse width", byte_done, 1'b0);

    // R6 inputs ignored while busy
    do_clr();
    @(negedge clk);
    byte_vld = 1'b1;
    byte_dat = 8'hC5;
    @(negedge clk);
    byte_dat = 8'h77;
    bit_vld = 1'b1;
    bit_dat = 1'b1;
    repeat (5) @(negedge clk);
    byte_vld = 1'b0;
    bit_vld = 1'b0;
    lat = 0;
    while (!byte_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R6 ignore while busy", crc, ref_byte(8'h00, 8'hC5));
    @(negedge clk);
    check("R6 no extra work", busy, 1'b0);

    // R7 simultaneous bit and byte
    do_clr();
    @(negedge clk);
    byte_vld = 1'b1;
    byte_dat = 8'h96;
    bit_vld = 1'b1;
    bit_dat = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
    bit_vld = 1'b0;
    lat = 0;
    while (!byte_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R7 byte wins", crc, ref_byte(8'h00, 8'h96));

    // R2 clear during byte
    send_bit(1'b1);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_dat = 8'hE1;
    @(negedge clk);
    byte_vld = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    bit_vld = 1'b1;
    bit_dat = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    bit_vld = 1'b0;
    check("R2 crc cleared", crc, 8'h00);
    check("R2 busy cleared", busy, 1'b0);
    lat = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (byte_done || crc != 8'h00) lat++;
    end
    check("R2 no done after abort", lat, 0);

    summary();
  end
endmodule